// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block observes the clock and data wires of an SMBus segment and raises two indications for the surrounding bus controller. The first is a stuck-clock timeout. A counter is kept at zero while the clock wire is high and advances on every system clock while it is low. When the low time reaches a configured limit, the block issues a one-cycle pulse. The limit is normally set to the cycle count that equals 25 ms. The controller uses that pulse to recover: it turns its bus interface off and back on. The second indication is a bus-free flag. It rises once both wires have been continuously high for more than a fixed number of periods of the SMBus clock source. Those periods arrive as a one-cycle tick input, so the idle count does not depend on the system clock rate.

Both raw wires first pass through a synchronizer with a reset value of high (idle). Each indication has its own enable. Clearing an enable holds that detector at its reset state.

Top module: `smbus_idle_watch`

## Requirements
- R1: While `rst_n` is low, `tmo_pulse` and `bus_free` are 0. All synchronizer stages reset to 1, meaning both wires idle high.
- R2: A raw wire level reaches the detectors after SYNC_STAGES clock edges, default two. Lowering `sda_in` just after edge n clears `bus_free` on edge n+3, so it still reads 1 after edge n+2.
- R3: With `tmo_en` = 1, `tmo_pulse` is 1 for exactly one cycle, right after the TMO_LIMIT-th consecutive edge at which the synchronized SCL was low.
- R4: Any edge with the synchronized SCL high restarts the low count. A low run of TMO_LIMIT-1 edges followed by a high level gives no pulse.
- R5: After a pulse, no further pulse occurs while SCL stays low. A new low run that follows a high level can pulse again.
- R6: With `free_en` = 1, `bus_free` rises right after the (FREE_TICKS+1)-th edge that has `src_tick` = 1 while both synchronized wires are high. It then stays 1 while both wires stay high.
- R7: Idle time is measured only in `src_tick` periods. Both wires high with `src_tick` = 0 never sets `bus_free`, however many system clocks pass.
- R8: An edge that sees either synchronized wire low clears the idle count and drives `bus_free` to 0 after that edge.
- R9: With `tmo_en` = 0, `tmo_pulse` stays 0. With `free_en` = 0, `bus_free` stays 0. Each detector restarts from zero when its enable is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_en | input | 1 | Enables the SCL-low timeout detector |
| free_en | input | 1 | Enables the bus-free detector |
| src_tick | input | 1 | One-cycle strobe, one per SMBus clock-source period |
| scl_in | input | 1 | Raw SCL wire level |
| sda_in | input | 1 | Raw SDA wire level |
| tmo_pulse | output | 1 | One-cycle pulse on SCL-low timeout |
| bus_free | output | 1 | Bus idle long enough to be considered free |

## Verification
Both results are registered behind the synchronizer. A raw SCL fall therefore yields its timeout pulse in the cycle after edge 2+TMO_LIMIT, counting from the first edge that samples the low level. A raw low on either wire removes `bus_free` after the third edge. The bench keeps a cycle model in which the raw levels pass through two delay slots before they feed the run-length counts. It drives inputs on the falling clock edge, advances the model at the rising edge and compares both outputs on the following falling edge, so every comparison lands in the cycle where the result is due. Directed runs pin down the exact pulse cycle, the limit-minus-one miss, the two-versus-three-edge drop of `bus_free`, tick-less idle time and the enables. A seeded random phase then mixes segment lengths, tick density and enable changes.

// File: rtl/smbus_watch_pkg.sv
package smbus_watch_pkg;

    // Pair of bus wires carried together through the synchronizer
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;

    localparam bus_lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync
    import smbus_watch_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  bus_lines_t raw,
    output bus_lines_t synced
);

    bus_lines_t stage_d [STAGES];
    bus_lines_t stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_d[g] = raw;
        end else begin : g_next
            assign stage_d[g] = stage_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= LINES_IDLE;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign synced = stage_q[STAGES-1];

endmodule

// File: rtl/smbus_low_timer.sv
module smbus_low_timer #(
    parameter int LIMIT = 1_200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_s,
    output logic pulse
);

    localparam int            CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          spent;
        logic          pulse;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (!en || scl_s) begin
            r_d.cnt   = '0;
            r_d.spent = 1'b0;
        end else if (!r_q.spent) begin
            if (r_q.cnt == LAST) begin
                r_d.spent = 1'b1;
                r_d.pulse = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pulse = r_q.pulse;

endmodule

// File: rtl/smbus_free_detect.sv
module smbus_free_detect #(
    parameter int TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic scl_s,
    input  logic sda_s,
    output logic bus_free
);

    localparam int            CW   = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          free;
    } idle_t;

    idle_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!en || !scl_s || !sda_s) begin
            r_d = '0;
        end else if (tick && !r_q.free) begin
            if (r_q.cnt == LAST) r_d.free = 1'b1;
            else                 r_d.cnt  = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_free = r_q.free;

endmodule

// File: rtl/smbus_idle_watch.sv
module smbus_idle_watch
    import smbus_watch_pkg::*;
#(
    parameter int TMO_LIMIT   = 1_200_000,
    parameter int FREE_TICKS  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tmo_en,
    input  logic free_en,
    input  logic src_tick,
    input  logic scl_in,
    input  logic sda_in,
    output logic tmo_pulse,
    output logic bus_free
);

    bus_lines_t raw_lines;
    bus_lines_t sync_lines;
    logic       scl_s;
    logic       sda_s;

    assign raw_lines = '{scl: scl_in, sda: sda_in};
    assign scl_s     = sync_lines.scl;
    assign sda_s     = sync_lines.sda;

    smbus_line_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_lines),
        .synced (sync_lines)
    );

    smbus_low_timer #(
        .LIMIT (TMO_LIMIT)
    ) i_low_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tmo_en),
        .scl_s (scl_s),
        .pulse (tmo_pulse)
    );

    smbus_free_detect #(
        .TICKS (FREE_TICKS)
    ) i_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (free_en),
        .tick     (src_tick),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .bus_free (bus_free)
    );

endmodule

// File: rtl/smbus_idle_watch_chk.sv
module smbus_idle_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic tmo_en,
    input logic free_en,
    input logic src_tick,
    input logic scl_s,
    input logic sda_s,
    input logic tmo_pulse,
    input logic bus_free
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tmo_pulse |=> !tmo_pulse); // R3
    AST_PULSE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n) tmo_pulse |-> $past(!scl_s)); // R3
    AST_HIGH_BLOCKS_PULSE: assert property (@(posedge clk) disable iff (!rst_n) scl_s |=> !tmo_pulse); // R4
    AST_FREE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_free) |-> $past(src_tick)); // R7
    AST_LOW_CLEARS_FREE: assert property (@(posedge clk) disable iff (!rst_n) (!scl_s || !sda_s) |=> !bus_free); // R8
    AST_TMO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !tmo_en |=> !tmo_pulse); // R9
    AST_FREE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) !free_en |=> !bus_free); // R9

endmodule

bind smbus_idle_watch smbus_idle_watch_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmo_en    (tmo_en),
    .free_en   (free_en),
    .src_tick  (src_tick),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .tmo_pulse (tmo_pulse),
    .bus_free  (bus_free)
);

// File: tb/test_smbus_idle_watch.sv
module test_smbus_idle_watch;

    localparam int CLK_PERIOD = 10;
    localparam int L = 40;
    localparam int F = 10;

    logic clk = 1'b0;
    logic rst_n, tmo_en, free_en, src_tick, scl_in, sda_in;
    logic tmo_pulse, bus_free;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_idle_watch #(.TMO_LIMIT(L), .FREE_TICKS(F), .SYNC_STAGES(2)) i_smbus_idle_watch (
        .clk(clk), .rst_n(rst_n), .tmo_en(tmo_en), .free_en(free_en),
        .src_tick(src_tick), .scl_in(scl_in), .sda_in(sda_in),
        .tmo_pulse(tmo_pulse), .bus_free(bus_free)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Reference model: two delay slots per wire, then run lengths
    bit m_scl1, m_scl2, m_sda1, m_sda2;
    int low_run, hi_ticks;
    bit e_pulse, e_free;
    int pulses_seen;
    int cyc;

    function automatic bit pulse_due(int run);
        return run == L;
    endfunction

    function automatic bit free_due(int ticks);
        return ticks > F;
    endfunction

    task automatic model_reset();
        m_scl1 = 1; m_scl2 = 1; m_sda1 = 1; m_sda2 = 1;
        low_run = 0; hi_ticks = 0; e_pulse = 0; e_free = 0;
    endtask

    task automatic model_edge();
        if (tmo_en && !m_scl2) low_run++; else low_run = 0;
        e_pulse = pulse_due(low_run);
        if (free_en && m_scl2 && m_sda2) begin
            if (src_tick) hi_ticks++;
        end else begin
            hi_ticks = 0;
        end
        e_free = free_due(hi_ticks);
        m_scl2 = m_scl1; m_scl1 = scl_in;
        m_sda2 = m_sda1; m_sda1 = sda_in;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One clock: inputs already driven at a falling edge
    task automatic cycle(string ptag, string ftag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc++;
        if (tmo_pulse) pulses_seen++;
        check(tmo_pulse == e_pulse, ptag, tmo_pulse, e_pulse);
        check(bus_free == e_free, ftag, bus_free, e_free);
    endtask

    task automatic drive(bit scl, bit sda, bit tick);
        scl_in = scl; sda_in = sda; src_tick = tick;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        cyc = 0;
        rst_n = 0; tmo_en = 1; free_en = 1;
        drive(0, 0, 1);
        model_reset();
        repeat (4) @(negedge clk);
        // R1: outputs low in reset
        check(tmo_pulse == 0, "R1", tmo_pulse, 0);
        check(bus_free == 0, "R1", bus_free, 0);
        drive(1, 1, 1);
        rst_n = 1;

        // R6: idle from reset, tick each cycle, free after 11 ticked edges
        for (int i = 0; i < 10; i++) cycle("R3", "R6");
        check(bus_free == 0, "R6", bus_free, 0);
        cycle("R3", "R6");
        check(bus_free == 1, "R6", bus_free, 1);
        for (int i = 0; i < 3; i++) cycle("R3", "R6");

        // R2 / R8: sda low, free still set after two edges, clear after three
        drive(1, 0, 1);
        cycle("R3", "R2");
        cycle("R3", "R2");
        check(bus_free == 1, "R2", bus_free, 1);
        cycle("R3", "R8");
        check(bus_free == 0, "R8", bus_free, 0);

        // R7: long idle with no ticks never frees the bus
        drive(1, 1, 0);
        for (int i = 0; i < 60; i++) cycle("R3", "R7");
        check(bus_free == 0, "R7", bus_free, 0);

        // R4: low run one short of the limit, then high
        pulses_seen = 0;
        drive(0, 1, 0);
        for (int i = 0; i < L - 1; i++) cycle("R4", "R8");
        drive(1, 1, 0);
        for (int i = 0; i < 5; i++) cycle("R4", "R8");
        check(pulses_seen == 0, "R4", pulses_seen, 0);

        // R3: pulse exactly after cycle L+2 from raw fall
        pulses_seen = 0;
        drive(0, 1, 0);
        for (int i = 1; i <= L + 6; i++) begin
            cycle("R3", "R8");
            if (i == L + 2) check(tmo_pulse == 1, "R3", tmo_pulse, 1);
            if (i == L + 3) check(tmo_pulse == 0, "R3", tmo_pulse, 0);
        end
        check(pulses_seen == 1, "R3", pulses_seen, 1);

        // R5: no repeat while low; new pulse after a high gap
        pulses_seen = 0;
        for (int i = 0; i < 100; i++) cycle("R5", "R8");
        check(pulses_seen == 0, "R5", pulses_seen, 0);
        drive(1, 1, 0);
        for (int i = 0; i < 4; i++) cycle("R5", "R8");
        drive(0, 1, 0);
        for (int i = 0; i < L + 4; i++) cycle("R5", "R8");
        check(pulses_seen == 1, "R5", pulses_seen, 1);

        // R9: enables clear hold both outputs low
        tmo_en = 0; free_en = 0;
        pulses_seen = 0;
        for (int i = 0; i < 2 * L; i++) cycle("R9", "R9");
        drive(1, 1, 1);
        for (int i = 0; i < 30; i++) cycle("R9", "R9");
        check(pulses_seen == 0, "R9", pulses_seen, 0);
        check(bus_free == 0, "R9", bus_free, 0);
        tmo_en = 1; free_en = 1;
        for (int i = 0; i < 14; i++) cycle("R9", "R9");
        check(bus_free == 1, "R9", bus_free, 1);

        // Random segments checked against the model
        for (int seg = 0; seg < 120; seg++) begin
            int len;
            int mode;
            bit s, d;
            mode = int'($urandom_range(0, 9));
            len  = (mode < 2) ? int'($urandom_range(L - 3, L + 8)) : int'($urandom_range(1, 25));
            s = (mode < 2) ? 1'b0 : 1'($urandom_range(0, 3) != 0);
            d = 1'($urandom_range(0, 4) != 0);
            if ($urandom_range(0, 15) == 0) tmo_en = ~tmo_en;
            if ($urandom_range(0, 15) == 0) free_en = ~free_en;
            for (int i = 0; i < len; i++) begin
                drive(s, d, 1'($urandom_range(0, 2) == 0));
                cycle("R3", "R6");
            end
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule